// File: doc/BRIEF.md
# Indirect Buffer Access Port

This block lets a host reach a local buffer RAM through a handful of I/O registers instead of a memory-mapped window. The host first sets a buffer pointer by writing twice to one address port: low half first, then high half. It then moves bytes or 16-bit words through a data port, and the pointer steps forward after every transfer. Any other access to the chip between the two address writes abandons the load.

The direction of the pipe is sampled only when the pointer is loaded. In read mode a load starts a prefetch of the addressed word into a read latch. Each data-port read hands back the latched value and fetches the next word. In write mode each data-port write goes straight through to the RAM. A busy output tells the host to hold off while a RAM operation is outstanding. The pipe works only while its enable bit is set and the memory-window enable is clear. While the pipe is active, memory-space decoding of the buffer is turned off.

Top module: `iopipe_top`

## Requirements
- R1: The first address-port write (port code 0) after a completed or cancelled sequence stores hostWdata[7:0] as the pending low half. It does not change the pointer and starts no RAM operation.
- R2: The next address-port write loads the pointer with {hostWdata[7:0], pending low half}. If the readMode input is 1 at that write, ramRd rises on the following cycle with ramAddr equal to the loaded pointer.
- R3: Any other host access to the block (data ports code 1 and 2, other register code 3, or a read of the address port) between the two address writes cancels the load. The pointer keeps its old value, and the next address write counts as a first write.
- R4: pipeActive is pipeEn AND NOT memWinEn, and memDecodeEn is low while pipeActive is high. While the pipe is inactive, host accesses change nothing and hostRdata is 0.
- R5: In read mode, a low-data-port read (code 1) made while not busy returns the latched word when hostWide=1, or the zero-extended low byte when hostWide=0. hostRdata is valid in the same cycle as hostRd. ramRd holds until ramAck.
- R6: After each accepted data transfer the pointer advances by 1 for a byte or by 2 for a word. In read mode the next prefetch is issued at the advanced pointer.
- R7: In write mode, a low-data-port write made while not busy raises ramWr on the next cycle, with ramAddr at the current pointer, ramWdata equal to hostWdata, and ramBe set to 2'b01 for a byte or 2'b11 for a word. ramAddr stays stable until ramAck.
- R8: The direction is latched from readMode only when the pointer is loaded; reset latches write mode. A data access in the other direction is ignored: no RAM operation, no pointer change, and hostRdata is 0.
- R9: A byte access to the high data port (code 2) is ignored. A word transfer goes through the low port, with hostWdata[15:8] written to the byte at pointer+1.
- R10: While busy is high, every host access is ignored, except that it still cancels a pending first address write.
- R11: After reset, busy, ramRd, ramWr and hostRdata are 0 and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pipeEn | input | 1 | Pipe enable control bit |
| memWinEn | input | 1 | Memory window enable control bit |
| readMode | input | 1 | Direction to latch at pointer load (1 = read) |
| hostSel | input | 2 | Register select: 0 address, 1 data low, 2 data high, 3 other |
| hostRd | input | 1 | Host read strobe, one cycle |
| hostWr | input | 1 | Host write strobe, one cycle |
| hostWide | input | 1 | 1 = 16-bit transfer, 0 = byte |
| hostWdata | input | 16 | Host write data |
| hostRdata | output | 16 | Host read data, valid during hostRd |
| busy | output | 1 | RAM operation outstanding |
| pipeActive | output | 1 | Pipe mode active |
| memDecodeEn | output | 1 | Memory-space decode of the buffer allowed |
| ramRd | output | 1 | RAM read request, held until ramAck |
| ramWr | output | 1 | RAM write request, held until ramAck |
| ramAddr | output | 16 | RAM byte address |
| ramBe | output | 2 | RAM byte enables |
| ramWdata | output | 16 | RAM write data |
| ramAck | input | 1 | RAM completion pulse |
| ramRdata | input | 16 | RAM read data, valid with ramAck |

## Verification
The bench uses the default widths: a 16-bit buffer address and 8-bit bytes. It uses a RAM model with a three-cycle acknowledge latency, so busy stays high for several cycles. That latency lets the bench hit the busy window with both address writes and data reads. The model keeps 256 bytes, indexed by the low address byte. Pointers with a nonzero upper byte therefore show that the high half is loaded, while every expected datum stays computable. Odd-address word reads and the wrap of the pointer across byte lanes are reached through mixed byte and word sequences.

// File: rtl/iopipe_pkg.sv
package iopipe_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR  = 2'd0,
    SEL_DLO   = 2'd1,
    SEL_DHI   = 2'd2,
    SEL_OTHER = 2'd3
  } portSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capLow;
    logic loadPtr;
    logic advance;
    logic wide;
    logic reqAtPtr;
    logic reqAtNext;
    logic latchRd;
    logic readOut;
  } pipeStrb_t;
endpackage

// File: rtl/iopipe_ctrl.sv
module iopipe_ctrl
  import iopipe_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      pipeEn,
  input  logic      memWinEn,
  input  logic      readMode,
  input  logic [1:0] hostSel,
  input  logic      hostRd,
  input  logic      hostWr,
  input  logic      hostWide,
  input  logic      ramAck,
  output pipeStrb_t strb,
  output logic      busy,
  output logic      pipeActive,
  output logic      ramRd,
  output logic      ramWr
);
  logic haveLow, dirRead, reqRd, reqWr;
  logic hostAcc, addrWr, dataOk, rdOk, wrOk;

  assign pipeActive = pipeEn & ~memWinEn;
  assign busy       = reqRd | reqWr;
  assign ramRd      = reqRd;
  assign ramWr      = reqWr;

  always_comb begin
    hostAcc = pipeActive & (hostRd | hostWr);
    addrWr  = hostAcc & hostWr & ~hostRd & (hostSel == SEL_ADDR) & ~busy;
    dataOk  = hostAcc & ~busy & (hostSel == SEL_DLO);
    rdOk    = dataOk & hostRd & ~hostWr & dirRead;
    wrOk    = dataOk & hostWr & ~hostRd & ~dirRead;
    strb           = '0;
    strb.wide      = hostWide;
    strb.capLow    = addrWr & ~haveLow;
    strb.loadPtr   = addrWr & haveLow;
    strb.advance   = rdOk | wrOk;
    strb.reqAtPtr  = wrOk;
    strb.reqAtNext = rdOk | (addrWr & haveLow & readMode);
    strb.latchRd   = ramAck & reqRd;
    strb.readOut   = rdOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      haveLow <= 1'b0;
      dirRead <= 1'b0;
      reqRd   <= 1'b0;
      reqWr   <= 1'b0;
    end else begin
      // any access either arms the sequence (first write) or clears it
      if (hostAcc) haveLow <= strb.capLow;
      if (strb.loadPtr) dirRead <= readMode;
      if (ramAck) begin
        reqRd <= 1'b0;
        reqWr <= 1'b0;
      end
      if (strb.reqAtNext) reqRd <= 1'b1;
      if (wrOk) reqWr <= 1'b1;
    end
  end

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ramRd && !ramAck) |=> ramRd);
  p_load_fetch_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadPtr && readMode) |=> ramRd);
  p_cancel_r3: assert property (@(posedge clk) disable iff (!rstN)
    (haveLow && pipeActive && (hostRd || hostWr) &&
     !(hostWr && !hostRd && hostSel == SEL_ADDR)) |=> !haveLow);
  p_off_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!pipeActive && !busy) |=> !busy);
  p_one_req_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(ramRd && ramWr));
endmodule

// File: rtl/iopipe_dp.sv
module iopipe_dp
  import iopipe_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  pipeStrb_t           strb,
  input  logic                busy,
  input  logic                ramAck,
  input  logic [2*BYTE_W-1:0] hostWdata,
  input  logic [2*BYTE_W-1:0] ramRdata,
  output logic [2*BYTE_W-1:0] hostRdata,
  output logic [ADDR_W-1:0]   ramAddr,
  output logic [1:0]          ramBe,
  output logic [2*BYTE_W-1:0] ramWdata
);
  localparam int HALF   = ADDR_W / 2;
  localparam int WORD_W = 2 * BYTE_W;

  logic [ADDR_W-1:0] ptr, ptrNext, step;
  logic [HALF-1:0]   tempLow;
  logic [WORD_W-1:0] rdLatch;

  assign step = strb.wide ? ADDR_W'(2) : ADDR_W'(1);

  always_comb begin
    if (strb.loadPtr)      ptrNext = {hostWdata[HALF-1:0], tempLow};
    else if (strb.advance) ptrNext = ptr + step;
    else                   ptrNext = ptr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr      <= '0;
      tempLow  <= '0;
      rdLatch  <= '0;
      ramAddr  <= '0;
      ramBe    <= 2'b00;
      ramWdata <= '0;
    end else begin
      ptr <= ptrNext;
      if (strb.capLow) tempLow <= hostWdata[HALF-1:0];
      if (strb.reqAtNext) begin
        ramAddr <= ptrNext;
        ramBe   <= 2'b11;
      end
      if (strb.reqAtPtr) begin
        ramAddr  <= ptr;
        ramWdata <= hostWdata;
        ramBe    <= strb.wide ? 2'b11 : 2'b01;
      end
      if (strb.latchRd) rdLatch <= ramRdata;
    end
  end

  always_comb begin
    if (!strb.readOut)  hostRdata = '0;
    else if (strb.wide) hostRdata = rdLatch;
    else                hostRdata = {{BYTE_W{1'b0}}, rdLatch[BYTE_W-1:0]};
  end

  p_cap_keeps_ptr_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.capLow |=> (ptr == $past(ptr)));
  p_byte_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.wide) |=> (ptr == $past(ptr) + ADDR_W'(1)));
  p_addr_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !ramAck) |=> $stable(ramAddr));
endmodule

// File: rtl/iopipe_top.sv
module iopipe_top
  import iopipe_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pipeEn,
  input  logic                memWinEn,
  input  logic                readMode,
  input  logic [1:0]          hostSel,
  input  logic                hostRd,
  input  logic                hostWr,
  input  logic                hostWide,
  input  logic [2*BYTE_W-1:0] hostWdata,
  output logic [2*BYTE_W-1:0] hostRdata,
  output logic                busy,
  output logic                pipeActive,
  output logic                memDecodeEn,
  output logic                ramRd,
  output logic                ramWr,
  output logic [ADDR_W-1:0]   ramAddr,
  output logic [1:0]          ramBe,
  output logic [2*BYTE_W-1:0] ramWdata,
  input  logic                ramAck,
  input  logic [2*BYTE_W-1:0] ramRdata
);
  pipeStrb_t strb;

  assign memDecodeEn = memWinEn & ~pipeActive;

  iopipe_ctrl ctrl_i (
    .clk, .rstN, .pipeEn, .memWinEn, .readMode, .hostSel, .hostRd, .hostWr,
    .hostWide, .ramAck, .strb, .busy, .pipeActive, .ramRd, .ramWr
  );

  iopipe_dp #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) dp_i (
    .clk, .rstN, .strb, .busy, .ramAck, .hostWdata, .ramRdata,
    .hostRdata, .ramAddr, .ramBe, .ramWdata
  );

  p_no_decode_r4: assert property (@(posedge clk) disable iff (!rstN)
    pipeActive |-> !memDecodeEn);
endmodule

// File: tb/iopipe_top_tb_top.sv
module iopipe_top_tb_top;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rstN;
  logic        pipeEn, memWinEn, readMode;
  logic [1:0]  hostSel;
  logic        hostRd, hostWr, hostWide;
  logic [15:0] hostWdata, hostRdata;
  logic        busy, pipeActive, memDecodeEn, ramRd, ramWr;
  logic [15:0] ramAddr, ramWdata, ramRdata;
  logic [1:0]  ramBe;
  logic        ramAck;

  int nChecks = 0;
  int nFails  = 0;
  logic [15:0] expQ[$];
  string       tagQ[$];
  logic [7:0]  mem [256];
  int          cnt;

  always #10 clk = ~clk;

  iopipe_top dut_i (
    .clk, .rstN, .pipeEn, .memWinEn, .readMode, .hostSel, .hostRd, .hostWr,
    .hostWide, .hostWdata, .hostRdata, .busy, .pipeActive, .memDecodeEn,
    .ramRd, .ramWr, .ramAddr, .ramBe, .ramWdata, .ramAck, .ramRdata
  );

  function automatic logic [7:0] initByte(int i);
    return 8'(i * 13 + 5);
  endfunction

  // RAM model with fixed latency
  always @(posedge clk) begin
    if (!rstN) begin
      ramAck   <= 1'b0;
      ramRdata <= '0;
      cnt      <= 0;
      for (int i = 0; i < 256; i++) mem[i] <= initByte(i);
    end else if (ramAck) begin
      ramAck <= 1'b0;
      cnt    <= 0;
    end else if (ramRd || ramWr) begin
      if (cnt == LAT - 1) begin
        ramAck <= 1'b1;
        if (ramRd) ramRdata <= {mem[8'(ramAddr[7:0] + 8'd1)], mem[ramAddr[7:0]]};
        if (ramWr && ramBe[0]) mem[ramAddr[7:0]] <= ramWdata[7:0];
        if (ramWr && ramBe[1]) mem[8'(ramAddr[7:0] + 8'd1)] <= ramWdata[15:8];
      end else cnt <= cnt + 1;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // scoreboard monitor: every host read pops one expected value
  always begin
    @(negedge clk);
    #4;
    if (hostRd) begin
      if (expQ.size() == 0) chk(1'b0, "scoreboard-underflow", 32'(hostRdata), 0);
      else begin
        logic [15:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(hostRdata == e, t, 32'(hostRdata), 32'(e));
      end
    end
  end

  task automatic hostOp(input logic [1:0] sel, input logic rd, input logic wide,
                        input logic [15:0] data, input logic [15:0] expRd, input string tag);
    @(negedge clk);
    if (rd) begin
      expQ.push_back(expRd);
      tagQ.push_back(tag);
    end
    hostSel = sel; hostRd = rd; hostWr = ~rd; hostWide = wide; hostWdata = data;
    @(negedge clk);
    hostRd = 1'b0; hostWr = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  function automatic logic [15:0] initWord(int a);
    return {initByte((a + 1) % 256), initByte(a % 256)};
  endfunction

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    rstN = 1'b0; pipeEn = 1'b0; memWinEn = 1'b0; readMode = 1'b1;
    hostSel = 2'd0; hostRd = 1'b0; hostWr = 1'b0; hostWide = 1'b0; hostWdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(!busy && !ramRd && !ramWr, "R11 reset idle", {busy, ramRd, ramWr}, 0);
    chk(hostRdata == 0, "R11 reset rdata", 32'(hostRdata), 0);

    // R4 pipe disabled: address writes ignored
    hostOp(2'd0, 0, 0, 16'h0010, 0, "");
    hostOp(2'd0, 0, 0, 16'h0020, 0, "");
    @(negedge clk);
    chk(!ramRd && !pipeActive, "R4 off no load", {ramRd, pipeActive}, 0);
    hostOp(2'd1, 1, 1, 0, 16'h0000, "R4 off read zero");
    memWinEn = 1'b1; pipeEn = 1'b1; #1;
    chk(!pipeActive && memDecodeEn, "R4 window wins", {pipeActive, memDecodeEn}, 2'b01);
    memWinEn = 1'b0; #1;
    chk(pipeActive && !memDecodeEn, "R4 pipe active", {pipeActive, memDecodeEn}, 2'b10);

    // R1/R2 load in read mode
    hostOp(2'd0, 0, 0, 16'h0034, 0, "");
    chk(!ramRd, "R1 first write no fetch", 32'(ramRd), 0);
    hostOp(2'd0, 0, 0, 16'h0012, 0, "");
    chk(ramRd && ramAddr == 16'h1234, "R2 load fetch addr", 32'(ramAddr), 32'h1234);
    // R10 access while busy ignored
    hostOp(2'd1, 1, 1, 0, 16'h0000, "R10 busy read zero");
    chk(busy && ramAddr == 16'h1234, "R10 busy no move", 32'(ramAddr), 32'h1234);
    waitIdle();
    // R5/R6 word then byte reads
    hostOp(2'd1, 1, 1, 0, initWord(16'h34), "R5 word read");
    chk(ramRd && ramAddr == 16'h1236, "R6 word step", 32'(ramAddr), 32'h1236);
    waitIdle();
    hostOp(2'd1, 1, 0, 0, {8'h00, initByte(16'h36)}, "R5 byte read");
    chk(ramAddr == 16'h1237, "R6 byte step", 32'(ramAddr), 32'h1237);
    waitIdle();
    hostOp(2'd1, 1, 1, 0, initWord(16'h37), "R6 odd word read");
    waitIdle();

    // R3 cancellation
    hostOp(2'd0, 0, 0, 16'h0050, 0, "");
    hostOp(2'd3, 0, 0, 16'h0000, 0, "");
    hostOp(2'd0, 0, 0, 16'h0060, 0, "");
    chk(!ramRd, "R3 cancelled no load", 32'(ramRd), 0);
    hostOp(2'd0, 0, 0, 16'h0000, 0, "");
    chk(ramRd && ramAddr == 16'h0060, "R3 restart addr", 32'(ramAddr), 32'h0060);
    waitIdle();
    // R10 busy access cancels pending first write
    hostOp(2'd1, 1, 0, 0, {8'h00, initByte(16'h60)}, "R3 read after restart");
    hostOp(2'd0, 0, 0, 16'h0070, 0, "");
    chk(busy, "R10 still busy", 32'(busy), 1);
    waitIdle();
    hostOp(2'd0, 0, 0, 16'h0001, 0, "");
    chk(!ramRd, "R10 busy write not first", 32'(ramRd), 0);
    hostOp(2'd0, 0, 0, 16'h0000, 0, "");
    chk(ramAddr == 16'h0001, "R3 pair after busy", 32'(ramAddr), 32'h0001);
    waitIdle();

    // R7 write mode
    readMode = 1'b0;
    hostOp(2'd0, 0, 0, 16'h0040, 0, "");
    hostOp(2'd0, 0, 0, 16'h0000, 0, "");
    chk(!ramRd && !busy, "R7 write load no fetch", {ramRd, busy}, 0);
    hostOp(2'd1, 0, 0, 16'h33A5, 0, "");
    chk(ramWr && ramAddr == 16'h0040 && ramBe == 2'b01 && ramWdata[7:0] == 8'hA5,
        "R7 byte write", {ramAddr, 6'd0, ramBe, ramWdata[7:0]}, {16'h0040, 6'd0, 2'b01, 8'hA5});
    waitIdle();
    hostOp(2'd1, 0, 1, 16'hBEEF, 0, "");
    chk(ramWr && ramAddr == 16'h0041 && ramBe == 2'b11 && ramWdata == 16'hBEEF,
        "R7 word write", {ramAddr, ramWdata}, {16'h0041, 16'hBEEF});
    waitIdle();
    // R9 high port byte ignored
    hostOp(2'd2, 0, 0, 16'h0077, 0, "");
    chk(!ramWr && !busy, "R9 high byte ignored", {ramWr, busy}, 0);
    // R8 read in write mode ignored
    hostOp(2'd1, 1, 1, 0, 16'h0000, "R8 read in write mode zero");
    chk(!ramRd, "R8 no fetch", 32'(ramRd), 0);
    // R8 readMode change without reload: still writing
    readMode = 1'b1;
    hostOp(2'd1, 0, 1, 16'h1122, 0, "");
    chk(ramWr && ramAddr == 16'h0043, "R8 still write mode", 32'(ramAddr), 32'h0043);
    waitIdle();
    // reload in read mode and read back
    hostOp(2'd0, 0, 0, 16'h0040, 0, "");
    hostOp(2'd0, 0, 0, 16'h0000, 0, "");
    waitIdle();
    hostOp(2'd1, 0, 0, 16'h0099, 0, "");
    chk(!ramWr && !ramRd, "R8 write in read mode ignored", {ramWr, ramRd}, 0);
    hostOp(2'd1, 1, 1, 0, 16'hEFA5, "R9 word readback");
    waitIdle();
    hostOp(2'd1, 1, 0, 0, 16'h00BE, "R7 byte readback");
    waitIdle();
    hostOp(2'd1, 1, 1, 0, 16'h1122, "R8 readback");
    waitIdle();
    repeat (2) @(negedge clk);
    chk(expQ.size() == 0, "scoreboard drained", 32'(expQ.size()), 0);
    finishRun();
  end
endmodule